// File: doc/BRIEF.md
# Time-Multiplexed Pin-Sharing Link

This block lets many logical signals cross between two partitions of a design over only a few physical pins. A fast microcycle clock drives a one-hot sequencer. The sequencer walks through a fixed number of microcycles, and together those microcycles make up one emulated design cycle. In each microcycle the transmit side picks, for every pin, which logical signal drives it. The receive side loads each arriving pin value into the holding register of its destination signal. After the last microcycle the sequencer wraps back to the first one. A strobe that marks the end of the emulated cycle can be used as the emulated clock enable.

The schedule is fixed when the design is elaborated, through three parameter tables indexed by microcycle and pin:
- **Transmit source index.** A value below `NUM_SIG` selects a local input. A value at or above `NUM_SIG` selects holding register (value − `NUM_SIG`), which forwards an already received signal onward as an extra hop.
- **Receive destination index.**
- **Slot-valid flag.**

Some microcycles carry no valid slot. These are the logic-evaluation microcycles of each phase. A signal with no free slot in its phase is placed in a later phase.

The default schedule has 8 microcycles and 2 pins. Microcycles 0, 3 and 6 are idle on both pins. The other slots are listed below as source→destination for pin 0 / pin 1:
- Microcycle 1: 0→0 / 1→1
- Microcycle 2: 2→2 / 3→3
- Microcycle 4: 4→4 / 5→5
- Microcycle 5: 6→6 / idle
- Microcycle 7: 7→7 / source 8 (holding register 0)→8

Top module: `tmux_link`

## Requirements
- R1: While the synchronous reset `rst` is high, each clock edge sets `microState` to 1 (bit 0), clears every bit of `rxHold`, and leaves `endCycle` low.
- R2: Out of reset, `microState` always has exactly one bit set. It moves from bit m to bit m+1 on each clock edge and wraps from bit `NUM_MICRO`-1 to bit 0.
- R3: `endCycle` is high exactly during the microcycle in which `microState` bit `NUM_MICRO`-1 is set. It is therefore a one-clock pulse once every `NUM_MICRO` clocks.
- R4: During microcycle m, a pin p whose slot is valid drives the source given by TX_SRC[m][p]. An index below `NUM_SIG` selects `txSig` at that index. A higher index selects `rxHold` at (index − `NUM_SIG`).
- R5: A pin whose slot in the current microcycle is not valid drives 0.
- R6: A holding register `rxHold[d]` loads `pinIn[p]` only at the clock edge that ends a valid slot (m,p) with RX_DST[m][p] = d. At every other edge it keeps its value, whatever `pinIn` carries.
- R7: With the default schedule and `pinIn` looped back from `pinOut` during valid slots, `rxHold[i]` equals the `txSig[i]` of the emulated cycle just finished, for i in 0..7, after the clock edge that ends each `endCycle` microcycle. `rxHold[8]` equals that cycle's `txSig[0]`, delivered over the forwarded hop in microcycle 7.
- R8: With the default schedule, both pins drive 0 in microcycles 0, 3 and 6 (the evaluation microcycles), and pin 1 drives 0 in microcycle 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst | input | 1 | Synchronous reset, active high |
| txSig | input | NUM_SIG | Local logical signals to send, held stable over an emulated cycle |
| pinOut | output | NUM_PINS | Physical pins driven toward the other partition |
| pinIn | input | NUM_PINS | Physical pins arriving from the other partition |
| rxHold | output | NUM_RX | Holding registers of received logical signals |
| microState | output | NUM_MICRO | One-hot microcycle state |
| endCycle | output | 1 | One-microcycle pulse in the last microcycle of an emulated cycle |

## Verification
The bench drives random noise onto `pinIn` in every slot that is not valid. A receive side that captured in the wrong microcycle, or in every microcycle, would therefore corrupt the holding registers, and the end-of-cycle comparison would show it. The forwarded hop in microcycle 7 is checked against the current cycle's `txSig[0]`. A design that forwarded a stale register, or decoded the source index space wrongly, would deliver the previous cycle's value into `rxHold[8]`. Idle slots are checked to drive 0, and the wrap from the last microcycle to the first is checked together with the single-clock width of `endCycle`. A reset in the middle of a run must clear holding registers that are already full of data.

// File: rtl/tmux_link_pkg.sv
package tmux_link_pkg;

  // True when exactly one bit of a state vector is set (vector up to 64 bits).
  function automatic logic oneHotOk(input logic [63:0] vec);
    int unsigned ones;
    ones = 0;
    for (int i = 0; i < 64; i++) begin
      ones += int'(vec[i]);
    end
    return ones == 1;
  endfunction

endpackage

// File: rtl/tmux_link_seq.sv
module tmux_link_seq #(
  parameter int NUM_MICRO = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [NUM_MICRO-1:0] microOh,
  output logic                 endCycle
);
  import tmux_link_pkg::*;

  localparam logic [NUM_MICRO-1:0] FIRST_STATE = NUM_MICRO'(1);

  logic stateLegal;
  logic [NUM_MICRO-1:0] microNext;

  always_comb begin
    stateLegal = oneHotOk(64'(microOh));
    if (stateLegal) begin
      microNext = {microOh[NUM_MICRO-2:0], microOh[NUM_MICRO-1]};
    end else begin
      microNext = FIRST_STATE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      microOh <= FIRST_STATE;
    end else begin
      microOh <= microNext;
    end
  end

  assign endCycle = microOh[NUM_MICRO-1];

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (microOh == FIRST_STATE));

  assert_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot(microOh));

  assert_wrap_first_R3: assert property (@(posedge clk) disable iff (rst)
    endCycle |=> microOh[0]);

  assert_end_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    endCycle |=> !endCycle);

endmodule

// File: rtl/tmux_link_path.sv
module tmux_link_path #(
  parameter int NUM_SIG   = 8,
  parameter int NUM_RX    = 9,
  parameter int NUM_PINS  = 2,
  parameter int NUM_MICRO = 8,
  parameter int unsigned TX_SRC [NUM_MICRO][NUM_PINS] =
    '{'{0,0}, '{0,1}, '{2,3}, '{0,0}, '{4,5}, '{6,0}, '{0,0}, '{7,8}},
  parameter int unsigned RX_DST [NUM_MICRO][NUM_PINS] =
    '{'{0,0}, '{0,1}, '{2,3}, '{0,0}, '{4,5}, '{6,0}, '{0,0}, '{7,8}},
  parameter bit SLOT_VLD [NUM_MICRO][NUM_PINS] =
    '{'{1'b0,1'b0}, '{1'b1,1'b1}, '{1'b1,1'b1}, '{1'b0,1'b0},
      '{1'b1,1'b1}, '{1'b1,1'b0}, '{1'b0,1'b0}, '{1'b1,1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_MICRO-1:0] microOh,
  input  logic [NUM_SIG-1:0]   txSig,
  output logic [NUM_PINS-1:0]  pinOut,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_RX-1:0]    rxHold
);

  localparam int SRC_N = NUM_SIG + NUM_RX;
  localparam int SRC_W = $clog2(SRC_N);
  localparam int DST_W = (NUM_RX > 1) ? $clog2(NUM_RX) : 1;

  logic [SRC_N-1:0]     srcAll;
  logic [NUM_MICRO-1:0] slotMask;

  // Source space: local inputs first, then received values for forwarding.
  assign srcAll = {rxHold, txSig};

  // Microcycles that carry at least one valid slot on any pin.
  always_comb begin
    for (int m = 0; m < NUM_MICRO; m++) begin
      slotMask[m] = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        slotMask[m] = slotMask[m] | SLOT_VLD[m][p];
      end
    end
  end

  // Transmit: AND-OR of the active microcycle's valid slots per pin.
  always_comb begin
    pinOut = '0;
    for (int m = 0; m < NUM_MICRO; m++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (SLOT_VLD[m][p] && microOh[m]) begin
          pinOut[p] = srcAll[SRC_W'(TX_SRC[m][p])];
        end
      end
    end
  end

  // Receive: each holding register loads only in its assigned slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      rxHold <= '0;
    end else begin
      for (int m = 0; m < NUM_MICRO; m++) begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (SLOT_VLD[m][p] && microOh[m]) begin
            rxHold[DST_W'(RX_DST[m][p])] <= pinIn[p];
          end
        end
      end
    end
  end

  assert_hold_cleared_R1: assert property (@(posedge clk)
    rst |=> (rxHold == '0));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    ((microOh & slotMask) == '0) |=> $stable(rxHold));

endmodule

// File: rtl/tmux_link.sv
module tmux_link #(
  parameter int NUM_SIG   = 8,
  parameter int NUM_RX    = 9,
  parameter int NUM_PINS  = 2,
  parameter int NUM_MICRO = 8,
  parameter int unsigned TX_SRC [NUM_MICRO][NUM_PINS] =
    '{'{0,0}, '{0,1}, '{2,3}, '{0,0}, '{4,5}, '{6,0}, '{0,0}, '{7,8}},
  parameter int unsigned RX_DST [NUM_MICRO][NUM_PINS] =
    '{'{0,0}, '{0,1}, '{2,3}, '{0,0}, '{4,5}, '{6,0}, '{0,0}, '{7,8}},
  parameter bit SLOT_VLD [NUM_MICRO][NUM_PINS] =
    '{'{1'b0,1'b0}, '{1'b1,1'b1}, '{1'b1,1'b1}, '{1'b0,1'b0},
      '{1'b1,1'b1}, '{1'b1,1'b0}, '{1'b0,1'b0}, '{1'b1,1'b1}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SIG-1:0]   txSig,
  output logic [NUM_PINS-1:0]  pinOut,
  input  logic [NUM_PINS-1:0]  pinIn,
  output logic [NUM_RX-1:0]    rxHold,
  output logic [NUM_MICRO-1:0] microState,
  output logic                 endCycle
);

  logic [NUM_MICRO-1:0] microOh;

  tmux_link_seq #(
    .NUM_MICRO (NUM_MICRO)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .microOh  (microOh),
    .endCycle (endCycle)
  );

  tmux_link_path #(
    .NUM_SIG   (NUM_SIG),
    .NUM_RX    (NUM_RX),
    .NUM_PINS  (NUM_PINS),
    .NUM_MICRO (NUM_MICRO),
    .TX_SRC    (TX_SRC),
    .RX_DST    (RX_DST),
    .SLOT_VLD  (SLOT_VLD)
  ) u_path (
    .clk     (clk),
    .rst     (rst),
    .microOh (microOh),
    .txSig   (txSig),
    .pinOut  (pinOut),
    .pinIn   (pinIn),
    .rxHold  (rxHold)
  );

  assign microState = microOh;

endmodule

// File: tb/tmux_link_bench.sv
module tmux_link_bench;

  localparam int N_SIG = 8;
  localparam int N_RX  = 9;
  localparam int N_PIN = 2;
  localparam int N_MIC = 8;

  // Bench copy of the default schedule as stated in the requirements.
  localparam int unsigned B_SRC [N_MIC][N_PIN] =
    '{'{0,0}, '{0,1}, '{2,3}, '{0,0}, '{4,5}, '{6,0}, '{0,0}, '{7,8}};
  localparam bit B_VLD [N_MIC][N_PIN] =
    '{'{1'b0,1'b0}, '{1'b1,1'b1}, '{1'b1,1'b1}, '{1'b0,1'b0},
      '{1'b1,1'b1}, '{1'b1,1'b0}, '{1'b0,1'b0}, '{1'b1,1'b1}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst;
  logic [N_SIG-1:0] txSig;
  logic [N_PIN-1:0] pinOut;
  logic [N_PIN-1:0] pinIn;
  logic [N_RX-1:0]  rxHold;
  logic [N_MIC-1:0] microState;
  logic             endCycle;

  tmux_link u_tmux_link (
    .clk        (clk),
    .rst        (rst),
    .txSig      (txSig),
    .pinOut     (pinOut),
    .pinIn      (pinIn),
    .rxHold     (rxHold),
    .microState (microState),
    .endCycle   (endCycle)
  );

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  bit endSeen = 1'b0;
  int microIdx = 0;
  logic [N_SIG-1:0] curTx = '0;
  logic [N_RX-1:0]  expQ[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: new random inputs for one emulated cycle, expected result queued.
  task automatic driveCycle();
    txSig = N_SIG'($urandom);
    curTx = txSig;
    expQ.push_back({txSig[0], txSig});
  endtask

  always @(posedge clk) begin
    if (rst) microIdx <= 0;
    else     microIdx <= (microIdx == N_MIC - 1) ? 0 : microIdx + 1;
  end

  // Loopback in valid slots, noise everywhere else (exercises R6).
  always @(negedge clk) begin
    for (int p = 0; p < N_PIN; p++) begin
      pinIn[p] = B_VLD[microIdx][p] ? pinOut[p] : 1'($urandom);
    end
  end

  // Monitor: per-microcycle checks and end-of-cycle scoreboard compare.
  always @(negedge clk) begin
    if (running && !rst) begin
      check($countones(microState) == 1 && microState == N_MIC'(1 << microIdx),
            "R2 one-hot step", 32'(microState), 32'(1 << microIdx));
      check(endCycle == (microIdx == N_MIC - 1), "R3 end strobe",
            32'(endCycle), 32'(microIdx == N_MIC - 1));
      for (int p = 0; p < N_PIN; p++) begin
        logic expBit;
        if (!B_VLD[microIdx][p]) begin
          expBit = 1'b0;
          check(pinOut[p] == expBit, "R5 R8 idle pin", 32'(pinOut[p]), 32'(expBit));
        end else begin
          if (B_SRC[microIdx][p] < N_SIG) expBit = curTx[B_SRC[microIdx][p]];
          else                            expBit = curTx[0];
          check(pinOut[p] == expBit, "R4 slot source", 32'(pinOut[p]), 32'(expBit));
        end
      end
      if (endSeen) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7 queue empty", 32'(rxHold), 32'(0));
        end else begin
          logic [N_RX-1:0] expHold;
          expHold = expQ.pop_front();
          check(rxHold == expHold, "R6 R7 holds after cycle", 32'(rxHold), 32'(expHold));
        end
      end
      endSeen = endCycle;
    end else begin
      endSeen = 1'b0;
    end
  end

  initial begin
    rst = 1'b1;
    txSig = '0;
    pinIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(microState == N_MIC'(1), "R1 reset state", 32'(microState), 32'(1));
    check(rxHold == '0, "R1 reset holds", 32'(rxHold), 32'(0));
    check(endCycle == 1'b0, "R1 reset strobe", 32'(endCycle), 32'(0));
    driveCycle();
    rst = 1'b0;
    running = 1'b1;
    for (int c = 0; c < 300; c++) begin
      repeat (N_MIC) @(negedge clk);
      driveCycle();
    end
    repeat (N_MIC + 1) @(negedge clk);
    check(expQ.size() <= 1, "R7 all cycles compared", 32'(expQ.size()), 32'(1));
    running = 1'b0;
    // Mid-run reset with loaded holding registers.
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(rxHold == '0, "R1 mid-run reset holds", 32'(rxHold), 32'(0));
    check(microState == N_MIC'(1), "R1 mid-run reset state", 32'(microState), 32'(1));
    check(endCycle == 1'b0, "R1 mid-run reset strobe", 32'(endCycle), 32'(0));
    summary();
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

endmodule